// File: doc/BRIEF.md
# Bus Master Request and Ownership Controller

This block runs the request side of a bus master on a shared, PCI-style parallel bus. When the transfer engine has work pending, it raises the request line. It then watches the grant input together with the FRAME and IRDY lines driven by whichever agent currently owns the bus. When it sees grant held on an idle bus, it emits a one-cycle strobe. That strobe tells the transaction engine to drive address and command in the next cycle. The address is never stepped.

The request can be released at one of two points, chosen by a configuration bit. With the bit clear, the request drops in the cycle that the address phase of the final transaction begins. With the bit set, the request stays up until the engine reports that the final data phase has started. When several single-phase transactions share one ownership period, the request stays up across all of them.

A raised request cannot be withdrawn by a stop or suspend command. Only a hard or soft reset removes it. A stop or suspend command does keep a new request from being raised.

Top module: `bus_req_ctrl`

## Requirements
- R1: `addr_go` pulses only in the cycle after a rising edge at which grant was active and the bus was idle, that is FRAME and IRDY both deasserted. With the default parameter the bus pins are active-low, so a pin at 0 means asserted.
- R2: With `ext_req_cfg`=0, the request is deasserted in the same cycle that `addr_go` pulses for a transaction flagged `last_txn`=1.
- R3: With `ext_req_cfg`=1, the request stays asserted through the address phase and falls in the cycle after the edge at which `last_data_start` is sampled high for the final transaction.
- R4: While a request is raised, `halt_cmd` has no effect on it. The request is still asserted afterwards, and the ownership sequence completes normally.
- R5: Driving `rst_n` low deasserts the request pin at once, without waiting for a clock edge, and clears `addr_go`.
- R6: `soft_rst`=1 deasserts the request pin in the same cycle it is applied, and the controller returns to idle at the next edge.
- R7: For a run of transactions with `last_txn`=0, the request stays asserted across their address phases. After `last_data_start`, the controller waits for grant on an idle bus again. The request falls with the address phase of the transaction that has `last_txn`=1.
- R8: `addr_go` is a single-cycle pulse per transaction, and `addr_step_cap` always reads 0.
- R9: If grant is removed before the address phase starts, `addr_go` stays low and the request remains asserted.
- R10: While idle, `xfer_pend` with `halt_cmd`=1 does not raise a request. Once `halt_cmd` clears, the request rises at the next edge.
- R11: After reset, the request pin is deasserted and `addr_go` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, active high |
| xfer_pend | input | 1 | Transfer engine has work for the bus |
| halt_cmd | input | 1 | Stop or suspend command in effect |
| last_txn | input | 1 | Next transaction is the last of this ownership period |
| last_data_start | input | 1 | Engine is starting the final data phase |
| ext_req_cfg | input | 1 | 1 holds the request until the final data phase |
| bus_gnt | input | 1 | Grant from the central arbiter (pin polarity) |
| bus_frame | input | 1 | Observed FRAME line (pin polarity) |
| bus_irdy | input | 1 | Observed IRDY line (pin polarity) |
| bus_req | output | 1 | Request to the central arbiter (pin polarity) |
| addr_go | output | 1 | Bus owned; drive address and command next cycle |
| addr_step_cap | output | 1 | Address-stepping capability, always 0 |

## Verification
The checker enforces several rules on every cycle:
- a start strobe is always preceded by grant on an idle bus;
- the request never falls without a release event or a soft reset behind it;
- the extended-hold mode never drops the request early;
- the strobe is never two cycles long;
- losing grant while waiting never yields a start.

The bench scenarios cover what the per-cycle checks cannot. They show the exact cycle of release in both modes across a multi-transaction ownership period. They also show a stop command leaving a raised request untouched while blocking a new one, and the asynchronous effect of both resets on the pin.

// File: rtl/brq_pkg.sv
package brq_pkg;

  typedef enum logic [1:0] {
    BRQ_IDLE = 2'd0,
    BRQ_WAIT = 2'd1,
    BRQ_OWN  = 2'd2
  } brq_state_e;

  // Bus is free when neither FRAME nor IRDY is asserted (logical polarity).
  function automatic logic bus_is_free(logic frame_a, logic irdy_a);
    return !frame_a && !irdy_a;
  endfunction

  // The request is released together with the address phase only for the
  // final transaction when the extended hold is off.
  function automatic logic release_with_addr(logic last, logic ext_hold);
    return last && !ext_hold;
  endfunction

endpackage

// File: rtl/brq_pol.sv
module brq_pol #(
  parameter bit ACT_LOW = 1'b1
) (
  input  logic pin_gnt,
  input  logic pin_frame,
  input  logic pin_irdy,
  input  logic req_a,
  output logic gnt_a,
  output logic frame_a,
  output logic irdy_a,
  output logic pin_req
);
  generate
    if (ACT_LOW) begin : g_low
      assign gnt_a   = ~pin_gnt;
      assign frame_a = ~pin_frame;
      assign irdy_a  = ~pin_irdy;
      assign pin_req = ~req_a;
    end else begin : g_high
      assign gnt_a   = pin_gnt;
      assign frame_a = pin_frame;
      assign irdy_a  = pin_irdy;
      assign pin_req = req_a;
    end
  endgenerate
endmodule

// File: rtl/brq_idle_mon.sv
module brq_idle_mon
  import brq_pkg::*;
(
  input  logic gnt_a,
  input  logic frame_a,
  input  logic irdy_a,
  output logic bus_idle,
  output logic grant_ok
);
  assign bus_idle = bus_is_free(frame_a, irdy_a);
  assign grant_ok = gnt_a && bus_idle;
endmodule

// File: rtl/brq_seq.sv
module brq_seq
  import brq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       xfer_pend,
  input  logic       halt_cmd,
  input  logic       grant_ok,
  input  logic       last_txn,
  input  logic       ext_cfg,
  input  logic       last_data_start,
  output logic       req_q,
  output logic       start_q,
  output brq_state_e state
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BRQ_IDLE;
      req_q   <= 1'b0;
      start_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (soft_rst) begin
      state   <= BRQ_IDLE;
      req_q   <= 1'b0;
      start_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state)
        BRQ_IDLE: begin
          if (xfer_pend && !halt_cmd) begin
            state <= BRQ_WAIT;
            req_q <= 1'b1;
          end
        end
        BRQ_WAIT: begin
          if (grant_ok) begin
            state   <= BRQ_OWN;
            start_q <= 1'b1;
            last_q  <= last_txn;
            if (release_with_addr(last_txn, ext_cfg)) req_q <= 1'b0;
          end
        end
        BRQ_OWN: begin
          if (last_data_start) begin
            if (last_q) begin
              state <= BRQ_IDLE;
              req_q <= 1'b0;
            end else begin
              state <= BRQ_WAIT;
            end
          end
        end
        default: state <= BRQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_req_ctrl.sv
module bus_req_ctrl
  import brq_pkg::*;
#(
  parameter bit BUS_ACT_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic xfer_pend,
  input  logic halt_cmd,
  input  logic last_txn,
  input  logic last_data_start,
  input  logic ext_req_cfg,
  input  logic bus_gnt,
  input  logic bus_frame,
  input  logic bus_irdy,
  output logic bus_req,
  output logic addr_go,
  output logic addr_step_cap
);
  logic       gnt_a, frame_a, irdy_a;
  logic       bus_idle, grant_ok;
  logic       req_q, start_q, req_act, in_wait;
  brq_state_e state;

  brq_pol #(.ACT_LOW(BUS_ACT_LOW)) u_pol (
    .pin_gnt  (bus_gnt),
    .pin_frame(bus_frame),
    .pin_irdy (bus_irdy),
    .req_a    (req_act),
    .gnt_a    (gnt_a),
    .frame_a  (frame_a),
    .irdy_a   (irdy_a),
    .pin_req  (bus_req)
  );

  brq_idle_mon u_idle (
    .gnt_a   (gnt_a),
    .frame_a (frame_a),
    .irdy_a  (irdy_a),
    .bus_idle(bus_idle),
    .grant_ok(grant_ok)
  );

  brq_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_rst       (soft_rst),
    .xfer_pend      (xfer_pend),
    .halt_cmd       (halt_cmd),
    .grant_ok       (grant_ok),
    .last_txn       (last_txn),
    .ext_cfg        (ext_req_cfg),
    .last_data_start(last_data_start),
    .req_q          (req_q),
    .start_q        (start_q),
    .state          (state)
  );

  // Soft reset pulls the request off the pin within the same cycle.
  assign req_act       = req_q && !soft_rst;
  assign in_wait       = (state == BRQ_WAIT);
  assign addr_go       = start_q;
  assign addr_step_cap = 1'b0;
endmodule

// File: rtl/brq_chk.sv
module brq_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic gnt_a,
  input logic bus_idle,
  input logic req_act,
  input logic req_q,
  input logic start_q,
  input logic in_wait,
  input logic last_txn,
  input logic ext_cfg,
  input logic last_data_start
);
  AST_START_AFTER_IDLE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(gnt_a && bus_idle && !soft_rst)); // R1

  AST_EXT0_DROP_AT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && $past(last_txn && !ext_cfg)) |-> !req_act); // R2

  AST_EXT1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_act && ext_cfg && !last_data_start && !soft_rst) |=> (req_act || soft_rst)); // R3

  AST_REQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_act) |-> (soft_rst || start_q || $past(last_data_start))); // R4

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!req_q && !start_q)); // R6

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R8

  AST_GNT_LOST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !gnt_a && !soft_rst) |=> (!start_q && req_q)); // R9
endmodule

bind bus_req_ctrl brq_chk u_brq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_rst       (soft_rst),
  .gnt_a          (gnt_a),
  .bus_idle       (bus_idle),
  .req_act        (req_act),
  .req_q          (req_q),
  .start_q        (start_q),
  .in_wait        (in_wait),
  .last_txn       (last_txn),
  .ext_cfg        (ext_req_cfg),
  .last_data_start(last_data_start)
);

// File: tb/bus_req_ctrl_bench.sv
module bus_req_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, soft_rst, xfer_pend, halt_cmd, last_txn, last_data_start, ext_req_cfg;
  logic gnt_l, frame_l, irdy_l;
  logic bus_gnt, bus_frame, bus_irdy, bus_req, addr_go, addr_step_cap;

  // Default build: active-low pins, logical 1 drives the pin to 0.
  assign bus_gnt   = ~gnt_l;
  assign bus_frame = ~frame_l;
  assign bus_irdy  = ~irdy_l;

  always #(CLK_P/2) clk = ~clk;

  bus_req_ctrl u_bus_req_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_pend(xfer_pend),
    .halt_cmd(halt_cmd), .last_txn(last_txn), .last_data_start(last_data_start),
    .ext_req_cfg(ext_req_cfg), .bus_gnt(bus_gnt), .bus_frame(bus_frame),
    .bus_irdy(bus_irdy), .bus_req(bus_req), .addr_go(addr_go),
    .addr_step_cap(addr_step_cap)
  );

  typedef struct {
    int    cyc;
    logic  req;
    logic  go;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic check1(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endtask

  // Monitor: compare outputs a quarter period after each rising edge.
  always begin
    @(posedge clk);
    cyc++;
    #(CLK_P/4);
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      check1(e.tag, ~bus_req, e.req, "request");
      check1(e.tag, addr_go, e.go, "addr_go");
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // Driver-side expectation for the sample after the next rising edge.
  task automatic expect_nx(logic req, logic go, string tag);
    exp_t e;
    e.cyc = cyc + 1; e.req = req; e.go = go; e.tag = tag;
    sbq.push_back(e);
  endtask

  initial begin
    rst_n = 0; soft_rst = 0; xfer_pend = 0; halt_cmd = 0; last_txn = 0;
    last_data_start = 0; ext_req_cfg = 0; gnt_l = 0; frame_l = 0; irdy_l = 0;
    repeat (3) tick();
    check1("R11", bus_req, 1'b1, "req pin in reset");
    check1("R11", addr_go, 1'b0, "addr_go in reset");
    check1("R8", addr_step_cap, 1'b0, "step cap");
    rst_n = 1;

    // R1/R2: wait for grant and idle bus, release with the address phase
    tick(); xfer_pend = 1; last_txn = 1; expect_nx(1, 0, "R1");
    tick(); expect_nx(1, 0, "R1");
    tick(); gnt_l = 1; frame_l = 1; expect_nx(1, 0, "R1");
    tick(); frame_l = 0; irdy_l = 1; expect_nx(1, 0, "R1");
    tick(); irdy_l = 0; expect_nx(0, 1, "R2");
    tick(); xfer_pend = 0; expect_nx(0, 0, "R8");
    tick(); last_data_start = 1; expect_nx(0, 0, "R8");
    tick(); last_data_start = 0; gnt_l = 0; expect_nx(0, 0, "R2");

    // R3: extended hold until the final data phase
    tick(); ext_req_cfg = 1; xfer_pend = 1; gnt_l = 1; expect_nx(1, 0, "R3");
    tick(); xfer_pend = 0; expect_nx(1, 1, "R3");
    tick(); expect_nx(1, 0, "R3");
    tick(); last_data_start = 1; expect_nx(0, 0, "R3");
    tick(); last_data_start = 0; ext_req_cfg = 0; gnt_l = 0; expect_nx(0, 0, "R3");

    // R9: grant taken away before the address phase
    tick(); xfer_pend = 1; expect_nx(1, 0, "R9");
    tick(); gnt_l = 1; frame_l = 1; expect_nx(1, 0, "R9");
    tick(); gnt_l = 0; frame_l = 0; expect_nx(1, 0, "R9");
    tick(); expect_nx(1, 0, "R9");
    tick(); gnt_l = 1; expect_nx(0, 1, "R9");
    tick(); xfer_pend = 0; last_data_start = 1; expect_nx(0, 0, "R9");
    tick(); last_data_start = 0; gnt_l = 0; expect_nx(0, 0, "R9");

    // R10/R4: halt blocks a new request but cannot withdraw a raised one
    tick(); halt_cmd = 1; xfer_pend = 1; expect_nx(0, 0, "R10");
    tick(); expect_nx(0, 0, "R10");
    tick(); halt_cmd = 0; expect_nx(1, 0, "R10");
    tick(); halt_cmd = 1; expect_nx(1, 0, "R4");
    tick(); expect_nx(1, 0, "R4");
    tick(); gnt_l = 1; expect_nx(0, 1, "R4");
    tick(); xfer_pend = 0; halt_cmd = 0; last_data_start = 1; expect_nx(0, 0, "R4");
    tick(); last_data_start = 0; gnt_l = 0; expect_nx(0, 0, "R4");

    // R7: two single-phase transactions in one ownership period
    tick(); xfer_pend = 1; last_txn = 0; gnt_l = 1; expect_nx(1, 0, "R7");
    tick(); expect_nx(1, 1, "R7");
    tick(); frame_l = 1; expect_nx(1, 0, "R7");
    tick(); frame_l = 0; last_data_start = 1; expect_nx(1, 0, "R7");
    tick(); last_data_start = 0; last_txn = 1; expect_nx(0, 1, "R7");
    tick(); xfer_pend = 0; expect_nx(0, 0, "R7");
    tick(); last_data_start = 1; expect_nx(0, 0, "R7");
    tick(); last_data_start = 0; gnt_l = 0; expect_nx(0, 0, "R7");

    // R6: soft reset removes the request within the cycle
    tick(); xfer_pend = 1; expect_nx(1, 0, "R6");
    tick(); soft_rst = 1; #1;
    check1("R6", bus_req, 1'b1, "req pin during soft reset");
    expect_nx(0, 0, "R6");
    tick(); soft_rst = 0; xfer_pend = 0; expect_nx(0, 0, "R6");

    // R5: hard reset acts without a clock edge
    tick(); xfer_pend = 1; expect_nx(1, 0, "R5");
    tick(); expect_nx(1, 0, "R5");
    tick(); rst_n = 0; #1;
    check1("R5", bus_req, 1'b1, "req pin after hard reset");
    check1("R5", addr_go, 1'b0, "addr_go after hard reset");
    tick(); rst_n = 1; xfer_pend = 0; expect_nx(0, 0, "R5");
    repeat (3) tick();
    check1("R8", addr_step_cap, 1'b0, "step cap");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule